// File: doc/BRIEF.md
# SPI Register Front-End with Flag Handshakes

This block is the register layer that sits between a processor's byte-wide register bus and the shift engine of an SPI controller. It holds one transmit byte until the engine takes it. Received bytes are kept in a data register plus one pending slot. The block keeps three flags: receive full, transmit empty and mode fault. Each flag is cleared only by a fixed two-step sequence of bus accesses. It also watches the slave-select input and leaves master mode when another device pulls that line low.

Software reads the status register, then reads or writes the data register or writes the control register to complete a sequence. On the other side, the shift engine raises single-cycle pulses when a transfer starts, when a transfer finishes and when a received byte is ready. In master mode the block raises a request whenever a byte is queued and the engine is idle. The engine answers that request with a start pulse.

Top module: `spi_fe_regs`

## Requirements
- R1: Register select 0 is status, 1 is data, 2 is control and 3 reads as zero. In status, bit 7 is receive full, bit 5 is transmit empty, bit 4 is mode fault, and every other bit reads 0. Read data is combinational from the current register state.
- R2: After reset, status reads 0x20, the data register and control register read 0, no transmit byte is offered and no pending receive byte exists.
- R3: A data write is accepted only when a status read that saw transmit empty set came earlier with no data write in between. An accepted write loads the transmit byte and clears transmit empty. Any other data write changes neither the flag nor the transmit byte.
- R4: While transmit empty is clear, the queued byte is offered on tx_valid and tx_byte. A start pulse from the engine takes it, and transmit empty reads 1 again one cycle later.
- R5: master_go is high only in master mode (control bit 0) with a byte queued and the engine idle. Idle means no start pulse has come since the last done pulse. master_go rises in the cycle after the done pulse that ends a busy transfer.
- R6: A received byte that arrives while receive full is clear goes into the data register at once, and receive full sets.
- R7: A received byte that arrives while receive full is set is held as a valid pending byte, and the data register keeps its value.
- R8: Receive full is serviced by a status read that saw it set, later followed by a data read. If a pending byte is valid at that point, it moves into the data register and receive full stays set.
- R9: A start pulse while a pending byte is valid makes that byte invalid. A later service then clears receive full and leaves the data register unchanged.
- R10: Receive full clears only through the R8 sequence. A data read without the armed status read leaves it set. An armed status read stays armed across status and control accesses until the next data read.
- R11: With control bit 0 (master) and bit 1 (fault detect enable) both set, slave-select held low sets mode fault after SYNC_STAGES+1 clock edges. In the same edge, master mode ends (control bit 0 reads 0) and any queued transmit byte is dropped, so transmit empty reads 1. With either control bit clear, a low slave-select has no effect.
- R12: Mode fault clears only on a control write that comes after a status read that saw mode fault set. A control write without that read leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 2 | Register select: 0 status, 1 data, 2 control |
| bus_rd | input | 1 | Read strobe for the selected register |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data of the selected register |
| ss_n | input | 1 | Slave-select line, active low |
| eng_start | input | 1 | Transfer-start pulse from the shift engine |
| eng_done | input | 1 | Transfer-done pulse from the shift engine |
| eng_rx_valid | input | 1 | Received-byte-complete pulse |
| eng_rx_byte | input | DW | Received byte, valid with eng_rx_valid |
| tx_valid | output | 1 | A transmit byte is queued |
| tx_byte | output | DW | Queued transmit byte |
| master_go | output | 1 | Request to start a master transfer |
| master_mode | output | 1 | Master mode is active |

## Verification
The receive path is driven with three patterns. A single byte sets the flag. Two bytes with service before any new start show the pending byte moving up. Two bytes followed by a start show the pending byte dropped. The transmit path is tried with an unarmed write, an armed write, and an armed write that comes after control and data-read accesses, so arm persistence is separated from arm loss. The fault path is run with slave-select low in slave mode and then in master mode, and the flag is cleared with and without the arming read. A behavioural model is compared against every output on every cycle across all of these patterns.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
   typedef enum logic [1:0] {
      SEL_STAT = 2'd0,
      SEL_DATA = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   localparam int RXF_POS  = 7;
   localparam int TXE_POS  = 5;
   localparam int MODF_POS = 4;
endpackage

// File: rtl/spi_fe_txbuf.sv
module spi_fe_txbuf #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_stat,
   input  logic          wr_data,
   input  logic [DW-1:0] wdata,
   input  logic          eng_start,
   input  logic          eng_done,
   input  logic          drop,
   input  logic          master,
   output logic          txe,
   output logic [DW-1:0] hold,
   output logic          master_go
);
   logic arm;
   logic busy;
   logic accept;
   logic consume;

   assign accept  = wr_data && arm && txe;
   assign consume = eng_start && !txe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm <= 1'b0;
      end else if (rd_stat && txe) begin
         arm <= 1'b1;
      end else if (wr_data) begin
         arm <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txe  <= 1'b1;
         hold <= '0;
      end else if (drop) begin
         txe <= 1'b1;
      end else if (accept) begin
         txe  <= 1'b0;
         hold <= wdata;
      end else if (consume) begin
         txe <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
      end else if (eng_start) begin
         busy <= 1'b1;
      end else if (eng_done) begin
         busy <= 1'b0;
      end
   end

   assign master_go = master && !txe && !busy;

   a_r3_fell_needs_arm : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(txe) |-> $past(wr_data && arm));
   a_r3_unarmed_ignored : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && !arm) |=> $stable(hold));
   a_r4_start_empties : assert property (@(posedge clk) disable iff (!rst_n)
      (eng_start && !txe) |=> txe);
endmodule

// File: rtl/spi_fe_rxbuf.sv
module spi_fe_rxbuf #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_stat,
   input  logic          rd_data,
   input  logic          eng_start,
   input  logic          rx_valid,
   input  logic [DW-1:0] rx_byte,
   output logic          rxf,
   output logic [DW-1:0] dreg
);
   logic          arm;
   logic          pend_v;
   logic [DW-1:0] pend;
   logic          svc;

   logic          rxf_a, pv_a, pv_b;
   logic [DW-1:0] dreg_a;
   logic          rxf_n, pv_n;
   logic [DW-1:0] dreg_n, pend_n;

   assign svc = rd_data && arm && rxf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm <= 1'b0;
      end else if (rd_stat && rxf) begin
         arm <= 1'b1;
      end else if (rd_data) begin
         arm <= 1'b0;
      end
   end

   always_comb begin
      rxf_a  = rxf;
      pv_a   = pend_v;
      dreg_a = dreg;
      if (svc) begin
         if (pend_v) begin
            dreg_a = pend;
            pv_a   = 1'b0;
         end else begin
            rxf_a = 1'b0;
         end
      end
      pv_b = pv_a && !eng_start;
      rxf_n  = rxf_a;
      pv_n   = pv_b;
      dreg_n = dreg_a;
      pend_n = pend;
      if (rx_valid) begin
         if (!rxf_a) begin
            dreg_n = rx_byte;
            rxf_n  = 1'b1;
         end else begin
            pend_n = rx_byte;
            pv_n   = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rxf    <= 1'b0;
         pend_v <= 1'b0;
         dreg   <= '0;
         pend   <= '0;
      end else begin
         rxf    <= rxf_n;
         pend_v <= pv_n;
         dreg   <= dreg_n;
         pend   <= pend_n;
      end
   end

   a_r6_direct_load : assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rxf) |=> (rxf && dreg == $past(rx_byte)));
   a_r7_hold_pending : assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rxf && !svc) |=> ($stable(dreg) && pend_v));
   a_r9_start_kills : assert property (@(posedge clk) disable iff (!rst_n)
      (eng_start && pend_v && !svc && !rx_valid) |=> !pend_v);
   a_r10_clear_needs_arm : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rxf) |-> $past(rd_data && arm));
endmodule

// File: rtl/spi_fe_fault.sv
module spi_fe_fault #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ss_n,
   input  logic master,
   input  logic detect_en,
   input  logic rd_stat,
   input  logic wr_ctrl,
   output logic fault_evt,
   output logic modf
);
   logic ss_s;
   logic arm;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign ss_s = ss_n;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= '1;
            end else begin
               chain <= {chain[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], ss_n} >> 0;
            end
         end
         assign ss_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   assign fault_evt = master && detect_en && !ss_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm <= 1'b0;
      end else if (rd_stat && modf) begin
         arm <= 1'b1;
      end else if (wr_ctrl) begin
         arm <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         modf <= 1'b0;
      end else if (fault_evt) begin
         modf <= 1'b1;
      end else if (wr_ctrl && arm && modf) begin
         modf <= 1'b0;
      end
   end

   a_r11_fault_sets : assert property (@(posedge clk) disable iff (!rst_n)
      fault_evt |=> modf);
   a_r12_clear_needs_write : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(modf) |-> $past(wr_ctrl && arm));
endmodule

// File: rtl/spi_fe_regs.sv
module spi_fe_regs #(
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2,
   parameter int MASTER_BIT  = 0,
   parameter int DETECT_BIT  = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    bus_sel,
   input  logic          bus_rd,
   input  logic          bus_wr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   input  logic          ss_n,
   input  logic          eng_start,
   input  logic          eng_done,
   input  logic          eng_rx_valid,
   input  logic [DW-1:0] eng_rx_byte,
   output logic          tx_valid,
   output logic [DW-1:0] tx_byte,
   output logic          master_go,
   output logic          master_mode
);
   import spi_fe_pkg::*;

   initial begin : p_param_check
      if (DW < 8) $fatal(1, "DW must be at least 8");
      if (MASTER_BIT >= DW || DETECT_BIT >= DW || MASTER_BIT == DETECT_BIT)
         $fatal(1, "control bit positions invalid");
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) $fatal(1, "SYNC_STAGES out of range");
   end

   reg_sel_e      sel;
   logic          rd_stat, rd_data, wr_data, wr_ctrl;
   logic [DW-1:0] ctrl;
   logic          fault_evt, modf, txe, rxf;
   logic [DW-1:0] hold, dreg, stat;

   assign sel     = reg_sel_e'(bus_sel);
   assign rd_stat = bus_rd && sel == SEL_STAT;
   assign rd_data = bus_rd && sel == SEL_DATA;
   assign wr_data = bus_wr && sel == SEL_DATA;
   assign wr_ctrl = bus_wr && sel == SEL_CTRL;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else begin
         if (wr_ctrl) ctrl <= bus_wdata;
         if (fault_evt) ctrl[MASTER_BIT] <= 1'b0;
      end
   end

   spi_fe_fault #(.SYNC_STAGES(SYNC_STAGES)) u_fault (
      .clk(clk), .rst_n(rst_n), .ss_n(ss_n),
      .master(ctrl[MASTER_BIT]), .detect_en(ctrl[DETECT_BIT]),
      .rd_stat(rd_stat), .wr_ctrl(wr_ctrl),
      .fault_evt(fault_evt), .modf(modf)
   );

   spi_fe_txbuf #(.DW(DW)) u_tx (
      .clk(clk), .rst_n(rst_n), .rd_stat(rd_stat), .wr_data(wr_data),
      .wdata(bus_wdata), .eng_start(eng_start), .eng_done(eng_done),
      .drop(fault_evt), .master(ctrl[MASTER_BIT]),
      .txe(txe), .hold(hold), .master_go(master_go)
   );

   spi_fe_rxbuf #(.DW(DW)) u_rx (
      .clk(clk), .rst_n(rst_n), .rd_stat(rd_stat), .rd_data(rd_data),
      .eng_start(eng_start), .rx_valid(eng_rx_valid), .rx_byte(eng_rx_byte),
      .rxf(rxf), .dreg(dreg)
   );

   always_comb begin
      stat           = '0;
      stat[RXF_POS]  = rxf;
      stat[TXE_POS]  = txe;
      stat[MODF_POS] = modf;
   end

   always_comb begin
      unique case (sel)
         SEL_STAT: bus_rdata = stat;
         SEL_DATA: bus_rdata = dreg;
         SEL_CTRL: bus_rdata = ctrl;
         default:  bus_rdata = '0;
      endcase
   end

   assign tx_valid    = !txe;
   assign tx_byte     = hold;
   assign master_mode = ctrl[MASTER_BIT];

   a_r11_leave_master : assert property (@(posedge clk) disable iff (!rst_n)
      fault_evt |=> (!master_mode && !tx_valid));
   a_r5_go_needs_byte : assert property (@(posedge clk) disable iff (!rst_n)
      master_go |-> (tx_valid && master_mode));
endmodule

// File: tb/spi_fe_regs_test.sv
module spi_fe_regs_test;
   localparam int DW = 8;
   localparam int SYNC = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    bus_sel = 2'd3;
   logic          bus_rd = 1'b0, bus_wr = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          ss_n = 1'b1;
   logic          eng_start = 1'b0, eng_done = 1'b0, eng_rx_valid = 1'b0;
   logic [DW-1:0] eng_rx_byte = '0;
   logic          tx_valid, master_go, master_mode;
   logic [DW-1:0] tx_byte;

   int n_run = 0;
   int n_fail = 0;
   bit live = 1'b0;

   spi_fe_regs #(.DW(DW), .SYNC_STAGES(SYNC)) uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ss_n(ss_n), .eng_start(eng_start), .eng_done(eng_done),
      .eng_rx_valid(eng_rx_valid), .eng_rx_byte(eng_rx_byte),
      .tx_valid(tx_valid), .tx_byte(tx_byte), .master_go(master_go),
      .master_mode(master_mode)
   );

   always #4 clk = ~clk;

   // behavioural reference state
   bit       m_rxf, m_txe, m_modf, m_pv, m_busy;
   bit       m_txarm, m_rxarm, m_mfarm;
   bit [7:0] m_data, m_pend, m_hold, m_ctrl;
   bit       ss_q[$];

   task automatic model_reset();
      m_rxf = 0; m_txe = 1; m_modf = 0; m_pv = 0; m_busy = 0;
      m_txarm = 0; m_rxarm = 0; m_mfarm = 0;
      m_data = 0; m_pend = 0; m_hold = 0; m_ctrl = 0;
      ss_q = {};
      for (int i = 0; i < SYNC; i++) ss_q.push_back(1'b1);
   endtask

   initial model_reset();

   always @(posedge clk) begin
      if (!rst_n) begin
         model_reset();
      end else begin
         bit rs, rdd, wd, wc, ss_s, flt, acc, svc;
         rs  = bus_rd && bus_sel == 2'd0;
         rdd = bus_rd && bus_sel == 2'd1;
         wd  = bus_wr && bus_sel == 2'd1;
         wc  = bus_wr && bus_sel == 2'd2;
         ss_s = ss_q[0];
         void'(ss_q.pop_front());
         ss_q.push_back(ss_n);
         flt = m_ctrl[0] && m_ctrl[1] && !ss_s;
         acc = wd && m_txarm && m_txe;
         svc = rdd && m_rxarm && m_rxf;
         // arms, from pre-edge flags
         if (rs && m_txe) m_txarm = 1; else if (wd) m_txarm = 0;
         if (rs && m_rxf) m_rxarm = 1; else if (rdd) m_rxarm = 0;
         if (rs && m_modf) m_mfarm = 1; else if (wc) m_mfarm = 0;
         // mode fault flag uses pre-edge arm captured above? use old arm
         if (flt) m_modf = 1;
         else if (wc && m_modf && !(rs) && mf_old) m_modf = 0;
         if (wc) m_ctrl = bus_wdata;
         if (flt) m_ctrl[0] = 0;
         // transmit side
         if (flt) m_txe = 1;
         else if (acc) begin m_txe = 0; m_hold = bus_wdata; end
         else if (eng_start && !m_txe) m_txe = 1;
         if (eng_start) m_busy = 1; else if (eng_done) m_busy = 0;
         // receive side: service, then start, then new byte
         if (svc) begin
            if (m_pv) begin m_data = m_pend; m_pv = 0; end
            else m_rxf = 0;
         end
         if (eng_start) m_pv = 0;
         if (eng_rx_valid) begin
            if (!m_rxf) begin m_data = eng_rx_byte; m_rxf = 1; end
            else begin m_pend = eng_rx_byte; m_pv = 1; end
         end
      end
      mf_old = m_mfarm;
   end

   // arm of the mode-fault sequence as it stood before the current edge
   bit mf_old = 0;

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit [7:0] m_rd(logic [1:0] s);
      case (s)
         2'd0: return {m_rxf, 1'b0, m_txe, m_modf, 4'b0};
         2'd1: return m_data;
         2'd2: return m_ctrl;
         default: return 8'h00;
      endcase
   endfunction

   always @(negedge clk) begin
      #1;
      if (live) begin
         chk((bus_sel == 2'd0) ? "R1 rdata" : "R8 rdata", bus_rdata, m_rd(bus_sel));
         chk("R4 tx_valid", {7'b0, tx_valid}, {7'b0, !m_txe});
         chk("R4 tx_byte", tx_byte, m_hold);
         chk("R5 master_go", {7'b0, master_go}, {7'b0, m_ctrl[0] && !m_txe && !m_busy});
         chk("R11 master_mode", {7'b0, master_mode}, {7'b0, m_ctrl[0]});
      end
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 200000) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   task automatic clr_pulses();
      bus_rd = 0; bus_wr = 0; eng_start = 0; eng_done = 0; eng_rx_valid = 0;
   endtask

   task automatic idle();
      @(negedge clk); clr_pulses(); bus_sel = 2'd3;
   endtask

   task automatic rd(logic [1:0] s);
      @(negedge clk); clr_pulses(); bus_sel = s; bus_rd = 1;
   endtask

   task automatic wr(logic [1:0] s, logic [7:0] d);
      @(negedge clk); clr_pulses(); bus_sel = s; bus_wr = 1; bus_wdata = d;
   endtask

   task automatic eng(bit st, bit dn, bit rv, logic [7:0] b);
      @(negedge clk); clr_pulses(); bus_sel = 2'd3;
      eng_start = st; eng_done = dn; eng_rx_valid = rv; eng_rx_byte = b;
   endtask

   // peek a register through the bus without a read strobe
   task automatic look(string tag, logic [1:0] s, logic [7:0] exp);
      @(negedge clk); clr_pulses(); bus_sel = s;
      #2;
      chk(tag, bus_rdata, exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      live = 1;
      look("R2 status after reset", 2'd0, 8'h20);
      look("R2 data after reset", 2'd1, 8'h00);
      look("R2 control after reset", 2'd2, 8'h00);
      chk("R2 no tx byte", {7'b0, tx_valid}, 8'h00);
      look("R1 select 3 reads zero", 2'd3, 8'h00);

      // unarmed write ignored
      wr(2'd1, 8'h55);
      look("R3 unarmed write ignored", 2'd0, 8'h20);
      chk("R3 unarmed no byte", {7'b0, tx_valid}, 8'h00);
      rd(2'd0);
      wr(2'd1, 8'h3C);
      idle(); #2;
      chk("R3 armed write queued", tx_byte, 8'h3C);
      chk("R4 byte offered", {7'b0, tx_valid}, 8'h01);
      look("R1 status tx full", 2'd0, 8'h00);
      eng(1, 0, 0, 0);
      eng(0, 1, 0, 0);
      look("R4 start empties", 2'd0, 8'h20);

      // arm survives other accesses
      rd(2'd0);
      wr(2'd2, 8'h00);
      rd(2'd1);
      wr(2'd1, 8'h77);
      idle(); #2;
      chk("R10 arm persists for write", tx_byte, 8'h77);
      eng(1, 0, 0, 0);
      eng(0, 1, 0, 0);

      // master request timing
      wr(2'd2, 8'h01);
      eng(1, 0, 0, 0);
      rd(2'd0);
      wr(2'd1, 8'h9A);
      idle(); #2;
      chk("R5 no go while busy", {7'b0, master_go}, 8'h00);
      eng(0, 1, 0, 0);
      idle(); #2;
      chk("R5 go after done", {7'b0, master_go}, 8'h01);
      eng(1, 0, 0, 0);
      eng(0, 1, 0, 0);
      wr(2'd2, 8'h00);

      // receive: direct, pending, service with move
      eng(0, 0, 1, 8'hA1);
      look("R6 direct load", 2'd1, 8'hA1);
      look("R6 flag set", 2'd0, 8'hA0);
      eng(0, 0, 1, 8'hB2);
      look("R7 data kept", 2'd1, 8'hA1);
      rd(2'd0);
      rd(2'd1);
      look("R8 pending moved", 2'd1, 8'hB2);
      look("R8 flag stays", 2'd0, 8'hA0);
      rd(2'd1);
      look("R10 unarmed read keeps flag", 2'd0, 8'hA0);
      rd(2'd0);
      wr(2'd2, 8'h00);
      rd(2'd1);
      look("R10 service clears", 2'd0, 8'h20);

      // receive: third start invalidates
      eng(0, 0, 1, 8'hD4);
      eng(0, 0, 1, 8'hE5);
      eng(1, 0, 0, 0);
      eng(0, 1, 0, 0);
      rd(2'd0);
      rd(2'd1);
      look("R9 flag clears", 2'd0, 8'h20);
      look("R9 data unchanged", 2'd1, 8'hD4);

      // mode fault
      ss_n = 0;
      repeat (5) idle();
      look("R11 no fault when slave", 2'd0, 8'h20);
      ss_n = 1;
      repeat (3) idle();
      wr(2'd2, 8'h03);
      rd(2'd0);
      wr(2'd1, 8'h11);
      idle(); #2;
      chk("R11 byte queued before fault", {7'b0, tx_valid}, 8'h01);
      @(negedge clk); clr_pulses(); ss_n = 0;
      repeat (SYNC + 1) idle();
      #2;
      chk("R11 byte dropped", {7'b0, tx_valid}, 8'h00);
      chk("R11 left master", {7'b0, master_mode}, 8'h00);
      look("R11 flag set", 2'd0, 8'h30);
      look("R11 control bit cleared", 2'd2, 8'h02);
      ss_n = 1;
      wr(2'd2, 8'h00);
      look("R12 unarmed write keeps flag", 2'd0, 8'h30);
      rd(2'd0);
      rd(2'd1);
      wr(2'd2, 8'h00);
      look("R12 armed write clears", 2'd0, 8'h20);
      repeat (4) idle();

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule